// File: doc/BRIEF.md
# Multi-Sector Transfer Sequencer

This block sequences the host side of sector transfers for a disk controller that moves data through a one-sector staging buffer. A command write latches a sector count, a starting sector number and two command bits: a direction bit (0 for the read-sector command, 1 for every other command) and a DMA-mode bit. The block then runs a loop of two phases. In the disk phase it waits for an abstracted disk side to report one sector as finished, with a fatal or correctable error class. In the buffer phase it raises a per-byte data request toward the host or DMA engine. Reads run the disk phase before the buffer phase, and writes run the buffer phase before the disk phase.

The task counters advance by one sector at the end of each completed sector. This leaves them showing exactly how far a transfer got. The controller interrupt is placed before or after the buffer hand-off, as the DMA bit selects. A system interrupt output forwards either that interrupt or an external DMA-done interrupt, as the latched direction bit selects. This lets partial-sector DMA reads finish on the DMA engine's signal. A strobe that accesses the cylinder-low register drops a stale data request.

Top module: `xfer_sequencer`

## Requirements
- R1: While reset is held, and after it is released, status (busy in bit 7, corrected in bit 2, error in bit 0), drq, ctrl_irq and both task counters are all zero.
- R2: With cmd_dma=1, a loaded sector count of 0 transfers 256 sectors.
- R3: With cmd_dma=1, a transfer that completes leaves sec_cnt at 0 and sec_num at the start number plus the number of sectors moved (modulo 256). Outside a command load, sec_cnt only holds or drops by one.
- R4: A disk completion with disk_fatal set ends the command. Error (bit 0) is set, busy clears and ctrl_irq rises. sec_num still names the failing sector, and sec_cnt holds the number of sectors not transferred.
- R5: A disk completion with disk_corr set (and no fatal error) sets corrected (bit 2), and a multi-sector transfer carries on.
- R6: With cmd_dma=0, a command moves one sector, and sec_cnt drops by one. On a read, ctrl_irq rises and busy clears as soon as the sector is in the buffer, before any byte is moved. With cmd_dma=1, a read raises ctrl_irq only after the last buffer has been moved.
- R7: In a buffer phase drq is high for each byte. It drops for one cycle after each accepted host_ack and rises again for the next byte. The phase ends after BYTES accepted bytes.
- R8: A sec_done pulse during a buffer phase ends the hand-off early, just like the final byte.
- R9: A cyl_access pulse drops drq on the next cycle, and drq stays low until a new buffer phase starts.
- R10: When the latched direction bit is 0, sys_irq follows dma_irq_in. When it is 1, sys_irq follows ctrl_irq.
- R11: A command write clears error, corrected and ctrl_irq. A stat_rd pulse clears ctrl_irq.
- R12: A write (cmd_nonread=1) fills the buffer first and then waits for the disk. ctrl_irq stays low and busy stays high until the last sector's disk completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command write strobe; also loads counters |
| cmd_nonread | input | 1 | Command direction bit: 0 read sector, 1 other |
| cmd_dma | input | 1 | Command DMA-mode bit |
| cnt_load | input | 8 | Sector count loaded on cmd_wr |
| num_load | input | 8 | Starting sector number loaded on cmd_wr |
| disk_done | input | 1 | Disk side finished one sector |
| disk_fatal | input | 1 | Fatal error class with disk_done |
| disk_corr | input | 1 | Correctable error class with disk_done |
| host_ack | input | 1 | Host or DMA moved the requested byte |
| sec_done | input | 1 | Ends the buffer hand-off early |
| cyl_access | input | 1 | Read or write of the cylinder-low register |
| stat_rd | input | 1 | Status read; clears ctrl_irq |
| dma_irq_in | input | 1 | External DMA-done interrupt |
| drq | output | 1 | Per-byte data request |
| status | output | 8 | Busy bit 7, corrected bit 2, error bit 0 |
| sec_cnt | output | 8 | Sector count register |
| sec_num | output | 8 | Sector number register |
| ctrl_irq | output | 1 | Controller interrupt |
| sys_irq | output | 1 | Selected system interrupt |

## Verification
The bench builds the block with BYTES=16 and keeps the 8-bit counters. The short sector makes a full 256-sector transfer from a zero count affordable in cycles, and also keeps every byte hand-off and counter step visible. The counters keep their default width, so the wrap of count zero and the sector-number roll-over are exercised at their real size.

// File: rtl/xs_pkg.sv
package xs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DISK = 2'd1,
    ST_BUF  = 2'd2
  } xs_state_t;

  localparam int STAT_BUSY = 7;
  localparam int STAT_CORR = 2;
  localparam int STAT_ERR  = 0;
endpackage

// File: rtl/xs_byte_ctr.sv
module xs_byte_ctr #(
  parameter int BYTES = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic active,
  input  logic ack,
  input  logic sec_done,
  input  logic cyl_clr,
  output logic drq,
  output logic done
);
  localparam int BW = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam logic [BW-1:0] LAST = BW'(BYTES - 1);

  logic [BW-1:0] idx_q, idx_d;
  logic          drq_q, drq_d;
  logic          rearm_q, rearm_d;
  logic          take;

  assign take = active & ack & drq_q;
  assign done = active & ((take & (idx_q == LAST)) | sec_done);
  assign drq  = drq_q;

  always_comb begin
    idx_d   = idx_q;
    drq_d   = drq_q;
    rearm_d = rearm_q;
    if (start) begin
      idx_d   = '0;
      drq_d   = 1'b1;
      rearm_d = 1'b0;
    end else if (!active || done) begin
      drq_d   = 1'b0;
      rearm_d = 1'b0;
    end else if (take) begin
      idx_d   = idx_q + BW'(1);
      drq_d   = 1'b0;
      rearm_d = 1'b1;
    end else if (cyl_clr) begin
      drq_d   = 1'b0;
      rearm_d = 1'b0;
    end else if (rearm_q) begin
      drq_d   = 1'b1;
      rearm_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      drq_q   <= 1'b0;
      rearm_q <= 1'b0;
    end else begin
      idx_q   <= idx_d;
      drq_q   <= drq_d;
      rearm_q <= rearm_d;
    end
  end
endmodule

// File: rtl/xs_task_regs.sv
module xs_task_regs #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] cnt_in,
  input  logic [CW-1:0] num_in,
  input  logic          adv,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] num,
  output logic          last
);
  logic [CW-1:0] cnt_q, cnt_d, num_q, num_d;

  assign cnt  = cnt_q;
  assign num  = num_q;
  assign last = (cnt_q == CW'(1));

  always_comb begin
    cnt_d = cnt_q;
    num_d = num_q;
    if (load) begin
      cnt_d = cnt_in;
      num_d = num_in;
    end else if (adv) begin
      cnt_d = cnt_q - CW'(1);
      num_d = num_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      num_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      num_q <= num_d;
    end
  end
endmodule

// File: rtl/xs_irq_sel.sv
module xs_irq_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_wr,
  input  logic set,
  input  logic clr,
  input  logic src_ctrl,
  input  logic dma_irq,
  output logic ctrl_irq,
  output logic sys_irq
);
  logic irq_q, irq_d;

  assign ctrl_irq = irq_q;
  assign sys_irq  = src_ctrl ? irq_q : dma_irq;

  always_comb begin
    irq_d = irq_q;
    if (cmd_wr)   irq_d = 1'b0;
    else if (set) irq_d = 1'b1;
    else if (clr) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end
endmodule

// File: rtl/xfer_sequencer.sv
module xfer_sequencer #(
  parameter int BYTES = 512,
  parameter int CW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic          cmd_nonread,
  input  logic          cmd_dma,
  input  logic [CW-1:0] cnt_load,
  input  logic [CW-1:0] num_load,
  input  logic          disk_done,
  input  logic          disk_fatal,
  input  logic          disk_corr,
  input  logic          host_ack,
  input  logic          sec_done,
  input  logic          cyl_access,
  input  logic          stat_rd,
  input  logic          dma_irq_in,
  output logic          drq,
  output logic [7:0]    status,
  output logic [CW-1:0] sec_cnt,
  output logic [CW-1:0] sec_num,
  output logic          ctrl_irq,
  output logic          sys_irq
);
  import xs_pkg::*;

  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  xs_state_t state_q, state_d;
  logic busy_q, busy_d, err_q, err_d, corr_q, corr_d;
  logic dir_q, dir_d, dma_q, dma_d;
  logic adv, irq_set, start, buf_done, last, in_disk_w;

  assign in_disk_w = (state_q == ST_DISK);

  always_comb begin
    state_d = state_q;
    busy_d  = busy_q;
    err_d   = err_q;
    corr_d  = corr_q;
    dir_d   = dir_q;
    dma_d   = dma_q;
    adv     = 1'b0;
    irq_set = 1'b0;
    start   = 1'b0;
    if (cmd_wr) begin
      busy_d  = 1'b1;
      err_d   = 1'b0;
      corr_d  = 1'b0;
      dir_d   = cmd_nonread;
      dma_d   = cmd_dma;
      state_d = cmd_nonread ? ST_BUF : ST_DISK;
      start   = cmd_nonread;
    end else begin
      unique case (state_q)
        ST_DISK: if (disk_done) begin
          if (disk_fatal) begin
            err_d   = 1'b1;
            busy_d  = 1'b0;
            irq_set = 1'b1;
            state_d = ST_IDLE;
          end else begin
            corr_d = corr_q | disk_corr;
            if (!dir_q) begin
              state_d = ST_BUF;
              start   = 1'b1;
              if (!dma_q) begin
                irq_set = 1'b1;
                busy_d  = 1'b0;
              end
            end else begin
              adv = 1'b1;
              if (!dma_q || last) begin
                state_d = ST_IDLE;
                busy_d  = 1'b0;
                irq_set = 1'b1;
              end else begin
                state_d = ST_BUF;
                start   = 1'b1;
              end
            end
          end
        end
        ST_BUF: if (buf_done) begin
          if (!dir_q) begin
            adv = 1'b1;
            if (!dma_q || last) begin
              state_d = ST_IDLE;
              busy_d  = 1'b0;
              irq_set = dma_q;
            end else begin
              state_d = ST_DISK;
            end
          end else begin
            state_d = ST_DISK;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      corr_q  <= 1'b0;
      dir_q   <= 1'b0;
      dma_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      busy_q  <= busy_d;
      err_q   <= err_d;
      corr_q  <= corr_d;
      dir_q   <= dir_d;
      dma_q   <= dma_d;
    end
  end

  xs_byte_ctr #(.BYTES(BYTES)) u_bytes (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start   (start),
    .active  ((state_q == ST_BUF) && !cmd_wr),
    .ack     (host_ack),
    .sec_done(sec_done),
    .cyl_clr (cyl_access),
    .drq     (drq),
    .done    (buf_done)
  );

  xs_task_regs #(.CW(CW)) u_regs (
    .clk   (clk),
    .rst_n (rst_int_n),
    .load  (cmd_wr),
    .cnt_in(cnt_load),
    .num_in(num_load),
    .adv   (adv),
    .cnt   (sec_cnt),
    .num   (sec_num),
    .last  (last)
  );

  xs_irq_sel u_irq (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .cmd_wr  (cmd_wr),
    .set     (irq_set),
    .clr     (stat_rd),
    .src_ctrl(dir_q),
    .dma_irq (dma_irq_in),
    .ctrl_irq(ctrl_irq),
    .sys_irq (sys_irq)
  );

  always_comb begin
    status            = 8'h00;
    status[STAT_BUSY] = busy_q;
    status[STAT_CORR] = corr_q;
    status[STAT_ERR]  = err_q;
  end
endmodule

// File: rtl/xs_checker.sv
module xs_checker #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_wr,
  input logic          disk_done,
  input logic          disk_fatal,
  input logic          disk_corr,
  input logic          host_ack,
  input logic          cyl_access,
  input logic          drq,
  input logic [7:0]    status,
  input logic [CW-1:0] sec_cnt,
  input logic [CW-1:0] sec_num,
  input logic          in_disk
);
  assert_drq_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (drq && host_ack && !cmd_wr) |=> !drq);

  assert_cyl_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cyl_access && !cmd_wr && !disk_done) |=> !drq);

  assert_new_cmd_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> (!status[0] && !status[2]));

  assert_cnt_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> (sec_cnt == $past(sec_cnt) || sec_cnt == $past(sec_cnt) - CW'(1)));

  assert_fatal_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_disk && disk_done && disk_fatal && !cmd_wr)
      |=> (status[0] && !status[7] && $stable(sec_cnt) && $stable(sec_num)));

  assert_corr_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_disk && disk_done && disk_corr && !disk_fatal && !cmd_wr) |=> status[2]);
endmodule

bind xfer_sequencer xs_checker #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_wr    (cmd_wr),
  .disk_done (disk_done),
  .disk_fatal(disk_fatal),
  .disk_corr (disk_corr),
  .host_ack  (host_ack),
  .cyl_access(cyl_access),
  .drq       (drq),
  .status    (status),
  .sec_cnt   (sec_cnt),
  .sec_num   (sec_num),
  .in_disk   (in_disk_w)
);

// File: tb/xfer_sequencer_bench.sv
`timescale 1ns/1ps
module xfer_sequencer_bench;
  localparam int BYTES = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wr = 0, cmd_nonread = 0, cmd_dma = 0;
  logic [7:0] cnt_load = 0, num_load = 0;
  logic disk_done = 0, disk_fatal = 0, disk_corr = 0;
  logic host_ack = 0, sec_done = 0, cyl_access = 0, stat_rd = 0, dma_irq_in = 0;
  logic drq, ctrl_irq, sys_irq;
  logic [7:0] status, sec_cnt, sec_num;

  int n_chk = 0;
  int n_bad = 0;
  int gap_bad;

  always #2.5 clk = ~clk;

  xfer_sequencer #(.BYTES(BYTES), .CW(8)) u_xfer_sequencer (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_nonread(cmd_nonread),
    .cmd_dma(cmd_dma), .cnt_load(cnt_load), .num_load(num_load),
    .disk_done(disk_done), .disk_fatal(disk_fatal), .disk_corr(disk_corr),
    .host_ack(host_ack), .sec_done(sec_done), .cyl_access(cyl_access),
    .stat_rd(stat_rd), .dma_irq_in(dma_irq_in), .drq(drq), .status(status),
    .sec_cnt(sec_cnt), .sec_num(sec_num), .ctrl_irq(ctrl_irq), .sys_irq(sys_irq)
  );

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int n_sectors(input bit dma, input int cnt);
    if (!dma) return 1;
    return (cnt == 0) ? 256 : cnt;
  endfunction

  function automatic int n_moved(input bit dma, input int cnt, input int fat);
    int n = n_sectors(dma, cnt);
    return (fat >= 0 && fat < n) ? fat : n;
  endfunction

  task automatic issue(input bit nonread, input bit dma, input int cnt, input int num);
    cmd_wr = 1; cmd_nonread = nonread; cmd_dma = dma;
    cnt_load = 8'(cnt); num_load = 8'(num);
    @(negedge clk);
    cmd_wr = 0;
  endtask

  task automatic disk_sector(input bit fatal, input bit corr);
    disk_done = 1; disk_fatal = fatal; disk_corr = corr;
    @(negedge clk);
    disk_done = 0; disk_fatal = 0; disk_corr = 0;
  endtask

  task automatic move_bytes(input int n);
    for (int i = 0; i < n; i++) begin
      int g = 0;
      while (!drq && g < 50) begin @(negedge clk); g++; end
      host_ack = 1;
      @(negedge clk);
      host_ack = 0;
      if (drq) gap_bad++;
    end
  endtask

  task automatic run_xfer(input bit rd, input bit dma, input int cnt, input int num,
                          input int fat, input int cor);
    int n = n_sectors(dma, cnt);
    int moved = n_moved(dma, cnt, fat);
    gap_bad = 0;
    issue(!rd, dma, cnt, num);
    for (int s = 0; s < n; s++) begin
      if (rd) begin
        disk_sector(s == fat, s == cor);
        if (s == fat) break;
        if (!dma) begin
          chk("R6 pio irq before buffer", ctrl_irq, 1);
          chk("R6 pio busy low before buffer", status[7], 0);
        end
        move_bytes(BYTES);
        if (dma && s < n - 1) chk("R6 dma irq held mid transfer", ctrl_irq, 0);
      end else begin
        move_bytes(BYTES);
        if (s == 0) begin
          chk("R12 write irq low before disk", ctrl_irq, 0);
          chk("R12 write busy before disk", status[7], 1);
        end
        disk_sector(s == fat, s == cor);
        if (s == fat) break;
      end
    end
    chk("R3 count after", sec_cnt, (cnt - moved) & 255);
    chk("R3 number after", sec_num, (num + moved) & 255);
    chk("R4 error bit", status[0], (fat >= 0 && fat < n) ? 1 : 0);
    chk("R5 corrected bit", status[2], (cor >= 0 && cor < moved) ? 1 : 0);
    chk("R4 busy clear at end", status[7], 0);
    chk("R6 irq at end", ctrl_irq, 1);
    chk("R7 drq gap after every ack", gap_bad, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 reset status", status, 0);
    chk("R1 reset drq", drq, 0);
    chk("R1 reset irq", ctrl_irq, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 status after release", status, 0);
    chk("R1 count after release", sec_cnt, 0);
    chk("R1 number after release", sec_num, 0);

    // R2: zero count in DMA mode moves 256 sectors
    run_xfer(1, 1, 0, 8'h10, -1, -1);
    // R3 / R5: multi-sector read, correctable error continues
    run_xfer(1, 1, 4, 8'hFE, -1, 1);
    // R4: fatal on third sector of five
    run_xfer(1, 1, 5, 8'h20, 2, -1);
    // R6: programmed read, one sector only
    run_xfer(1, 0, 3, 8'h07, -1, -1);
    // R12: multi-sector write with fatal on second sector
    run_xfer(0, 1, 3, 8'h40, 1, 0);

    // R7: exact byte count per buffer phase
    issue(0, 0, 1, 5);
    disk_sector(0, 0);
    move_bytes(BYTES - 1);
    @(negedge clk);
    chk("R7 drq still high before last byte", drq, 1);
    move_bytes(1);
    @(negedge clk);
    chk("R7 drq low after last byte", drq, 0);
    chk("R7 count advanced after full buffer", sec_cnt, 0);

    // R8: partial hand-off
    issue(0, 1, 3, 9);
    disk_sector(0, 0);
    move_bytes(3);
    sec_done = 1; @(negedge clk); sec_done = 0;
    chk("R8 partial advances count", sec_cnt, 2);
    chk("R8 partial advances number", sec_num, 10);
    @(negedge clk);
    chk("R8 drq low after partial", drq, 0);

    // R9: cylinder-low access clears drq
    issue(0, 0, 1, 0);
    disk_sector(0, 0);
    chk("R9 drq up before clear", drq, 1);
    cyl_access = 1; @(negedge clk); cyl_access = 0;
    chk("R9 drq cleared", drq, 0);
    repeat (2) @(negedge clk);
    chk("R9 drq stays low", drq, 0);

    // R10: source select by direction bit (read latched here)
    dma_irq_in = 1; @(negedge clk);
    chk("R10 read follows dma irq high", sys_irq, 1);
    dma_irq_in = 0; @(negedge clk);
    chk("R10 read ignores ctrl irq", sys_irq, 0);
    chk("R10 ctrl irq is high", ctrl_irq, 1);
    run_xfer(0, 0, 1, 3, -1, -1);
    dma_irq_in = 0; @(negedge clk);
    chk("R10 write follows ctrl irq", sys_irq, 1);

    // R11: status read and new command clear
    stat_rd = 1; @(negedge clk); stat_rd = 0;
    chk("R11 stat read clears irq", ctrl_irq, 0);
    run_xfer(1, 1, 2, 0, 0, -1);
    issue(0, 1, 1, 0);
    chk("R11 new command clears error", status[0], 0);
    chk("R11 new command clears irq", ctrl_irq, 0);
    disk_sector(0, 0);
    move_bytes(BYTES);

    // random mix
    for (int t = 0; t < 12; t++) begin
      bit rd = 1'($urandom % 2);
      bit dm = 1'($urandom % 2);
      int c = 1 + int'($urandom % 5);
      int nm = int'($urandom % 256);
      int f = ($urandom % 3 == 0) ? int'($urandom % c) : -1;
      int r = ($urandom % 3 == 0) ? int'($urandom % c) : -1;
      run_xfer(rd, dm, c, nm, f, r);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule